// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of a single-precision fused multiply-add datapath. It takes an addend `z`, two multiplicands `x` and `y`, and a 3-bit operation select. It sorts each operand into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. From the operation select it forms the effective sign of the product and of the addend.

Many operand combinations fully decide the result: NaNs, infinities, and a zero product. For these the block produces the final 32-bit word and the invalid-operation flag itself. In every other case it raises `out_compute`, and the arithmetic datapath must produce the result from the effective signs the block supplies. The only rounding information the block uses is a round-down indication, which picks the sign of an exact zero sum.

The decision is a single verdict, chosen by priority from the operand classes. The verdicts, in priority order, are:

- `V_SNAN_Z`, `V_SNAN_X`, `V_SNAN_Y`
- `V_QNAN_Z`, `V_QNAN_X`, `V_QNAN_Y`
- `V_INF_TIMES_ZERO`
- `V_INF_CLASH`
- `V_PROD_INF`
- `V_ADDEND_INF`
- `V_ZERO_SUM`
- `V_ADDEND_PASS`
- `V_COMPUTE`

The first verdict whose condition holds is taken; each condition is given in the requirements below. Exactly one verdict is taken per operation, and each operation ends with one registered result. The output register moves from idle to holding a result whenever `in_valid` is high at a clock edge, and returns to idle when it is low.

Top module: `fmasr_top`

## Requirements
- R1: The operation select `in_op` is decoded as follows.

  | `in_op` | Operation | Product negated | Addend negated |
  |---|---|---|---|
  | 0 | plain multiply-add | no | no |
  | 1 | fused multiply-add | no | no |
  | 2 | fused multiply-subtract | yes | no |
  | 3 | negated multiply-subtract | yes | no |
  | 4 | multiply-subtract | no | yes |
  | 5 | negated multiply-add | yes | yes |
  | 6, 7 | reserved, treated as plain | no | no |

  `out_prod_sign` is x[31] XOR y[31], inverted when the product is negated. `out_add_sign` is z[31], inverted when the addend is negated.
- R2: A signalling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero) outranks any quiet NaN. Among signalling NaNs, z is chosen first, then x, then y. The chosen operand is returned with fraction bit 22 set, and `out_invalid` is 1.
- R3: If no signalling NaN is present, the first quiet NaN in the order z, x, y is returned unchanged, with `out_invalid` 0. No result is ever a signalling NaN.
- R4: An infinity times a zero, in either order, returns 0x7FC00000 with `out_invalid` 1.
- R5: This rule applies to an infinite product, where the other multiplicand is nonzero and neither operand is a NaN. If z is infinite with an effective sign different from the product sign, the result is 0x7FC00000 with `out_invalid` 1. Otherwise the result is an infinity with the product sign.
- R6: This rule applies to a zero product with a non-NaN z. If z is infinite, the result is an infinity with the effective addend sign. If z is finite and nonzero (normal or denormal), the result is z's magnitude with the effective addend sign.
- R7: This rule applies to a zero product with a zero z. If the product sign and the effective addend sign are equal, the result is a zero of that sign. If they differ, the result is +0, or -0 when `in_round_down` is 1.
- R8: If the product is finite and nonzero and z is infinite, the result is an infinity with the effective addend sign.
- R9: In every remaining case (both multiplicands finite and nonzero, z finite), `out_compute` is 1, `out_invalid` is 0 and `out_result` is 0.
- R10: Results appear one clock after the inputs are sampled. `out_valid` is `in_valid` delayed by one clock, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| in_op | input | 3 | Operation select (R1) |
| in_round_down | input | 1 | Rounding mode is round-down |
| in_z | input | 32 | Addend |
| in_x | input | 32 | First multiplicand |
| in_y | input | 32 | Second multiplicand |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 32 | Resolved result, zero when compute is requested |
| out_invalid | output | 1 | Invalid-operation flag |
| out_compute | output | 1 | Datapath must produce the result |
| out_prod_sign | output | 1 | Effective product sign |
| out_add_sign | output | 1 | Effective addend sign |

## Verification

**NaN priority and quieting.** The bench mixes signalling and quiet NaNs across all three operand slots. A resolver that scanned quiet NaNs first, or scanned the operands in the wrong order, would return the wrong payload. A resolver that forgot to quiet a signalling NaN would emit it unchanged and fail to raise the flag.

**Infinities meeting zeros or infinities.** The bench pairs infinities with zeros and with infinities of equal and opposite effective sign, under each negation mode. A sign error in the negation decode would turn a valid infinity into a spurious invalid, or an invalid case into an infinity.

**Exact zero sums.** Zero-plus-zero is exercised with both rounding indications and with all four sign pairings. Taking the sign from the wrong source would flip these results.

**Compute and valid handling.** Denormal multiplicands are checked to make sure they still request computation. Idle cycles between operations catch a `out_valid` that does not track `in_valid`.

// File: rtl/fmasr_pkg.sv
package fmasr_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO  = 3'd0,
        CLS_DNORM = 3'd1,
        CLS_NORM  = 3'd2,
        CLS_INF   = 3'd3,
        CLS_QNAN  = 3'd4,
        CLS_SNAN  = 3'd5
    } opnd_cls_e;

    typedef enum logic [2:0] {
        OP_MADD       = 3'd0,
        OP_MADD_FUSED = 3'd1,
        OP_MSUB_FUSED = 3'd2,
        OP_NMSUB      = 3'd3,
        OP_MSUB       = 3'd4,
        OP_NMADD      = 3'd5,
        OP_RSV6       = 3'd6,
        OP_RSV7       = 3'd7
    } op_sel_e;

    typedef enum logic [3:0] {
        V_SNAN_Z,
        V_SNAN_X,
        V_SNAN_Y,
        V_QNAN_Z,
        V_QNAN_X,
        V_QNAN_Y,
        V_INF_TIMES_ZERO,
        V_INF_CLASH,
        V_PROD_INF,
        V_ADDEND_INF,
        V_ZERO_SUM,
        V_ADDEND_PASS,
        V_COMPUTE
    } verdict_e;

endpackage

// File: rtl/fmasr_classify.sv
module fmasr_classify
    import fmasr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] opnd,
    output opnd_cls_e    cls
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = opnd[W-2 -: EXP_W];
    assign frac = opnd[FRAC_W-1:0];

    always_comb begin
        if (expo == '1) begin
            if (frac == '0)             cls = CLS_INF;
            else if (frac[FRAC_W-1])    cls = CLS_QNAN;
            else                        cls = CLS_SNAN;
        end else if (expo == '0) begin
            cls = (frac == '0) ? CLS_ZERO : CLS_DNORM;
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fmasr_decide.sv
module fmasr_decide
    import fmasr_pkg::*;
(
    input  opnd_cls_e z_cls,
    input  opnd_cls_e x_cls,
    input  opnd_cls_e y_cls,
    input  logic      z_sign,
    input  logic      x_sign,
    input  logic      y_sign,
    input  logic [2:0] op,
    output verdict_e  verdict,
    output logic      prod_sign,
    output logic      add_sign
);
    logic neg_prod, neg_add;
    logic prod_has_inf, prod_has_zero;

    always_comb begin
        neg_prod = 1'b0;
        neg_add  = 1'b0;
        unique case (op_sel_e'(op))
            OP_MSUB_FUSED, OP_NMSUB: neg_prod = 1'b1;
            OP_MSUB:                 neg_add  = 1'b1;
            OP_NMADD: begin
                neg_prod = 1'b1;
                neg_add  = 1'b1;
            end
            default: ;
        endcase
    end

    assign prod_sign     = x_sign ^ y_sign ^ neg_prod;
    assign add_sign      = z_sign ^ neg_add;
    assign prod_has_inf  = (x_cls == CLS_INF)  || (y_cls == CLS_INF);
    assign prod_has_zero = (x_cls == CLS_ZERO) || (y_cls == CLS_ZERO);

    always_comb begin
        if      (z_cls == CLS_SNAN) verdict = V_SNAN_Z;
        else if (x_cls == CLS_SNAN) verdict = V_SNAN_X;
        else if (y_cls == CLS_SNAN) verdict = V_SNAN_Y;
        else if (z_cls == CLS_QNAN) verdict = V_QNAN_Z;
        else if (x_cls == CLS_QNAN) verdict = V_QNAN_X;
        else if (y_cls == CLS_QNAN) verdict = V_QNAN_Y;
        else if (prod_has_inf) begin
            if (prod_has_zero)
                verdict = V_INF_TIMES_ZERO;
            else if (z_cls == CLS_INF && add_sign != prod_sign)
                verdict = V_INF_CLASH;
            else
                verdict = V_PROD_INF;
        end else if (z_cls == CLS_INF) begin
            verdict = V_ADDEND_INF;
        end else if (prod_has_zero) begin
            verdict = (z_cls == CLS_ZERO) ? V_ZERO_SUM : V_ADDEND_PASS;
        end else begin
            verdict = V_COMPUTE;
        end
    end
endmodule

// File: rtl/fmasr_assemble.sv
module fmasr_assemble
    import fmasr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W = 1 + EXP_W + FRAC_W
) (
    input  verdict_e     verdict,
    input  logic [W-1:0] z,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         prod_sign,
    input  logic         add_sign,
    input  logic         round_down,
    output logic [W-1:0] result,
    output logic         invalid,
    output logic         compute
);
    localparam logic [W-1:0] QUIET_BIT   = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-2:0] INF_MAG     = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    always_comb begin
        result  = '0;
        invalid = 1'b0;
        compute = 1'b0;
        unique case (verdict)
            V_SNAN_Z: begin result = z | QUIET_BIT; invalid = 1'b1; end
            V_SNAN_X: begin result = x | QUIET_BIT; invalid = 1'b1; end
            V_SNAN_Y: begin result = y | QUIET_BIT; invalid = 1'b1; end
            V_QNAN_Z:          result = z;
            V_QNAN_X:          result = x;
            V_QNAN_Y:          result = y;
            V_INF_TIMES_ZERO,
            V_INF_CLASH: begin result = DEFAULT_NAN; invalid = 1'b1; end
            V_PROD_INF:        result = {prod_sign, INF_MAG};
            V_ADDEND_INF:      result = {add_sign, INF_MAG};
            V_ZERO_SUM:        result = {(prod_sign == add_sign) ? add_sign : round_down,
                                         {(W-1){1'b0}}};
            V_ADDEND_PASS:     result = {add_sign, z[W-2:0]};
            V_COMPUTE:         compute = 1'b1;
            default:           compute = 1'b1;
        endcase
    end
endmodule

// File: rtl/fmasr_top.sv
module fmasr_top
    import fmasr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [2:0]   in_op,
    input  logic         in_round_down,
    input  logic [W-1:0] in_z,
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_invalid,
    output logic         out_compute,
    output logic         out_prod_sign,
    output logic         out_add_sign
);
    localparam int NOPS = 3;
    localparam logic [W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] opnd [NOPS];
    opnd_cls_e    cls  [NOPS];

    assign opnd[0] = in_z;
    assign opnd[1] = in_x;
    assign opnd[2] = in_y;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fmasr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .opnd (opnd[i]),
            .cls  (cls[i])
        );
    end

    verdict_e     verdict;
    logic         prod_sign, add_sign;
    logic [W-1:0] result_d;
    logic         invalid_d, compute_d;

    fmasr_decide i_decide (
        .z_cls     (cls[0]),
        .x_cls     (cls[1]),
        .y_cls     (cls[2]),
        .z_sign    (in_z[W-1]),
        .x_sign    (in_x[W-1]),
        .y_sign    (in_y[W-1]),
        .op        (in_op),
        .verdict   (verdict),
        .prod_sign (prod_sign),
        .add_sign  (add_sign)
    );

    fmasr_assemble #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_asm (
        .verdict    (verdict),
        .z          (in_z),
        .x          (in_x),
        .y          (in_y),
        .prod_sign  (prod_sign),
        .add_sign   (add_sign),
        .round_down (in_round_down),
        .result     (result_d),
        .invalid    (invalid_d),
        .compute    (compute_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_invalid   <= 1'b0;
            out_compute   <= 1'b0;
            out_prod_sign <= 1'b0;
            out_add_sign  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result    <= result_d;
                out_invalid   <= invalid_d;
                out_compute   <= compute_d;
                out_prod_sign <= prod_sign;
                out_add_sign  <= add_sign;
            end
        end
    end

    // Checks on the registered stage against classifier outputs
    logic any_nan, inf_zero_hit;
    always_comb begin
        any_nan = 1'b0;
        for (int i = 0; i < NOPS; i++)
            if (cls[i] == CLS_QNAN || cls[i] == CLS_SNAN) any_nan = 1'b1;
    end
    assign inf_zero_hit = !any_nan &&
        ((cls[1] == CLS_INF && cls[2] == CLS_ZERO) || (cls[1] == CLS_ZERO && cls[2] == CLS_INF));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_invalid_qnan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |->
            (out_result[W-2 -: EXP_W] == '1 && out_result[FRAC_W-1]));
    assert_no_snan_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_result[W-2 -: EXP_W] == '1 && !out_result[FRAC_W-1]
                        && out_result[FRAC_W-2:0] != '0));
    assert_compute_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_compute) |-> (!out_invalid && out_result == '0));
    assert_inf_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inf_zero_hit) |=> (out_invalid && out_result == DEFAULT_NAN));
endmodule

// File: tb/test_fmasr_top.sv
module test_fmasr_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_round_down = 1'b0;
    logic [31:0] in_z = '0, in_x = '0, in_y = '0;
    logic        out_valid, out_invalid, out_compute, out_prod_sign, out_add_sign;
    logic [31:0] out_result;

    fmasr_top i_fmasr_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_round_down(in_round_down), .in_z(in_z), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
        .out_compute(out_compute), .out_prod_sign(out_prod_sign), .out_add_sign(out_add_sign)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] res;
        logic        inv;
        logic        cmp;
        logic        ps;
        logic        as_;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [31:0] P1 = 32'h3F800000, N1 = 32'hBF800000, P2 = 32'h40000000;
    localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
    localparam logic [31:0] PZ = 32'h0, NZ = 32'h80000000, DN = 32'h00000001;
    localparam logic [31:0] DNAN = 32'h7FC00000;

    // kind: 0 zero, 1 finite nonzero, 2 inf, 3 qnan, 4 snan
    function automatic int kind(logic [31:0] v);
        if (v[30:23] == 8'hFF) begin
            if (v[22:0] == 0) return 2;
            return v[22] ? 3 : 4;
        end
        return (v[30:0] == 0) ? 0 : 1;
    endfunction

    function automatic exp_t model(logic [31:0] z, logic [31:0] x, logic [31:0] y,
                                   logic [2:0] op, logic rd);
        exp_t e;
        logic [31:0] ops[3];
        logic np, na;
        int kz, kx, ky;
        bit hit;
        ops[0] = z; ops[1] = x; ops[2] = y;
        np = (op == 3'd2) || (op == 3'd3) || (op == 3'd5);
        na = (op == 3'd4) || (op == 3'd5);
        e.ps = x[31] ^ y[31] ^ np;
        e.as_ = z[31] ^ na;
        e.res = 0; e.inv = 0; e.cmp = 0; e.tag = "";
        kz = kind(z); kx = kind(x); ky = kind(y);
        hit = 0;
        for (int i = 0; i < 3; i++)
            if (!hit && kind(ops[i]) == 4) begin e.res = ops[i] | 32'h00400000; e.inv = 1; hit = 1; end
        for (int i = 0; i < 3; i++)
            if (!hit && kind(ops[i]) == 3) begin e.res = ops[i]; hit = 1; end
        if (hit) return e;
        if ((kx == 2 && ky == 0) || (kx == 0 && ky == 2)) begin
            e.res = DNAN; e.inv = 1;
        end else if (kx == 2 || ky == 2) begin
            if (kz == 2 && e.as_ != e.ps) begin e.res = DNAN; e.inv = 1; end
            else e.res = {e.ps, 31'h7F800000};
        end else if (kz == 2) begin
            e.res = {e.as_, 31'h7F800000};
        end else if (kx == 0 || ky == 0) begin
            if (kz == 0) e.res = (e.ps == e.as_) ? {e.as_, 31'h0} : {rd, 31'h0};
            else         e.res = {e.as_, z[30:0]};
        end else begin
            e.cmp = 1;
        end
        return e;
    endfunction

    task automatic send(logic [31:0] z, logic [31:0] x, logic [31:0] y,
                        logic [2:0] op, logic rd, string tag);
        exp_t e;
        @(negedge clk);
        in_z = z; in_x = x; in_y = y; in_op = op; in_round_down = rd; in_valid = 1'b1;
        e = model(z, x, y, op, rd);
        e.tag = tag;
        @(posedge clk);
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            @(posedge clk);
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    n_chk++;
                    if (!out_valid || out_result !== e.res || out_invalid !== e.inv ||
                        out_compute !== e.cmp || out_prod_sign !== e.ps || out_add_sign !== e.as_) begin
                        n_bad++;
                        $display("FAIL %s: got v=%0b res=%08h inv=%0b cmp=%0b ps=%0b as=%0b exp v=1 res=%08h inv=%0b cmp=%0b ps=%0b as=%0b",
                                 e.tag, out_valid, out_result, out_invalid, out_compute, out_prod_sign,
                                 out_add_sign, e.res, e.inv, e.cmp, e.ps, e.as_);
                    end
                end else if (out_valid) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R10: got out_valid=1 exp 0 on idle cycle");
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: got out_valid=%0b exp 0", out_valid);
        end
        rst_n = 1'b1;

        // R1 sign decode, all selects, compute path (R9)
        send(P1, P1, P2, 3'd0, 0, "R1 op0");
        send(P1, P1, P2, 3'd1, 0, "R1 op1");
        send(P1, P1, P2, 3'd2, 0, "R1 op2");
        send(P1, N1, P2, 3'd3, 0, "R1 op3");
        send(P1, P1, P2, 3'd4, 0, "R1 op4");
        send(N1, P1, P2, 3'd5, 0, "R1 op5");
        send(N1, N1, P2, 3'd6, 0, "R1 op6 reserved");
        send(P1, P1, N1, 3'd7, 0, "R1 op7 reserved");
        // R2 signalling NaN priority
        send(32'h7FC00001, P1, 32'h7F800003, 3'd0, 0, "R2 snan y beats qnan z");
        send(32'hFF800005, 32'h7F800007, P1, 3'd0, 0, "R2 snan z first");
        send(P1, 32'h7F800009, 32'hFF80000B, 3'd4, 0, "R2 snan x before y");
        // R3 quiet NaN order
        send(P1, 32'h7FC00011, 32'hFFC00013, 3'd0, 0, "R3 qnan x before y");
        send(32'hFFC00015, PINF, PZ, 3'd0, 0, "R3 qnan z over inf*0");
        send(P1, PINF, 32'h7FC00017, 3'd0, 0, "R3 qnan y");
        idle(2);
        // R4 inf times zero
        send(P1, PINF, PZ, 3'd0, 0, "R4 inf*0");
        send(NINF, NZ, NINF, 3'd5, 0, "R4 0*inf");
        // R5 infinite product
        send(NINF, PINF, P1, 3'd0, 0, "R5 clash");
        send(PINF, PINF, P1, 3'd0, 0, "R5 same sign inf");
        send(PINF, PINF, P1, 3'd4, 0, "R5 negated addend clash");
        send(P1, NINF, P2, 3'd0, 0, "R5 product sign");
        send(NINF, PINF, PINF, 3'd2, 0, "R5 negated product agrees");
        // R6 zero product
        send(NINF, PZ, P1, 3'd0, 0, "R6 zero*x + inf");
        send(NINF, PZ, P1, 3'd4, 0, "R6 negated inf addend");
        send(DN, P1, NZ, 3'd0, 0, "R6 denormal addend");
        send(P1, PZ, P2, 3'd4, 0, "R6 negated finite addend");
        // R7 zero sum
        send(NZ, PZ, P1, 3'd0, 0, "R7 differ rn");
        send(NZ, PZ, P1, 3'd0, 1, "R7 differ rd");
        send(NZ, NZ, P1, 3'd0, 1, "R7 equal neg");
        send(PZ, PZ, P1, 3'd0, 1, "R7 equal pos");
        send(PZ, PZ, P1, 3'd2, 0, "R7 negated product differ");
        // R8 finite product, infinite addend
        send(NINF, P1, P2, 3'd0, 0, "R8 inf addend");
        send(PINF, DN, P1, 3'd5, 0, "R8 denormal product");
        // R9 compute
        send(PZ, P1, P1, 3'd0, 0, "R9 zero addend");
        send(P1, DN, DN, 3'd0, 0, "R9 denormal product");
        idle(3);
        send(N1, P2, P2, 3'd1, 1, "R10 after idle");
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule